// File: doc/BRIEF.md
# Masked Vector Exponent Extractor

This block takes a vector of 64-bit IEEE double precision elements and, for each lane, replaces the element with the integer value of floor(log2|x|), itself written as a double. Denormal inputs are normalised first, so their exponents come out below -1022. Zero, infinity and NaN inputs have fixed results. Each lane also reports whether the operation was invalid or saw a denormal operand.

Around the per-lane unit sits a vector wrapper. A length select picks 2, 4 or 8 active lanes. A per-lane write mask then chooses between keeping the old destination lane (merging) and writing zero (zeroing). A broadcast option feeds element 0 of a memory-sourced operand to every lane. A reserved 4-bit field is checked, and any value other than all-ones flags an undefined opcode. The outputs are registered: the result for one set of inputs shows up on the outputs one clock later, and a new set of inputs can be given every cycle.

Top module: `vexp_lane_wrap`

## Requirements
- R1: Length select 0, 1, 2 gives 2, 4, 8 active lanes; the value 3 also gives 8. Destination bits from the active length up to bit 511 are zero.
- R2: For a finite non-zero, non-denormal lane x, the result is the double of (biased exponent - 1023), whatever the sign and fraction of x. An exponent of 1023 gives +0.0.
- R3: A denormal lane with DAZ low gives the double of (index of the highest set fraction bit - 1074) and raises the denormal flag. With DAZ high, a denormal gives -INF and does not raise the denormal flag.
- R4: A zero of either sign gives -INF (64'hFFF0000000000000). An infinity of either sign gives +INF (64'h7FF0000000000000).
- R5: A NaN lane gives the input with fraction bit 51 forced to 1 and all other bits kept. A NaN with bit 51 clear (signalling) raises the invalid flag.
- R6: An active lane is computed when the mask enable is low or when its mask bit (bit j for lane j) is set.
- R7: An active lane that is not computed keeps the previous destination lane when zero-mode is low, and becomes zero when zero-mode is high.
- R8: With broadcast and memory-source both high, every computed lane uses source bits [63:0]. Broadcast with memory-source low has no effect.
- R9: A reserved field other than 4'b1111 sets the undefined-opcode output. The whole destination then equals the previous destination input, and both flags are low.
- R10: The invalid and denormal flags are the OR of the computed lanes only. Masked lanes, and lanes at or beyond the active length, never raise a flag, and their mask bits have no effect.
- R11: All outputs are registered: they change only at a rising clock edge, one cycle after the inputs. Reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 512 | Source vector, lane j in bits [64j+63:64j] |
| prev_dst_i | input | 512 | Previous destination value |
| mask_i | input | 8 | Per-lane write mask |
| mask_en_i | input | 1 | Write mask in use |
| zero_mode_i | input | 1 | 1 = zeroing of masked lanes, 0 = merging |
| bcast_i | input | 1 | Broadcast element 0 |
| mem_src_i | input | 1 | Source comes from memory |
| vl_sel_i | input | 2 | Vector length select |
| daz_i | input | 1 | Treat denormal inputs as zero |
| rsvd_i | input | 4 | Reserved field, must be 4'b1111 |
| dst_o | output | 512 | Destination vector |
| inv_o | output | 1 | Invalid-operation flag |
| den_o | output | 1 | Denormal-operand flag |
| ud_o | output | 1 | Undefined-opcode indication |

## Verification
The exponent path is tried with ordinary normals of both signs, the largest and smallest normals, and an exponent of exactly 1023. These separate the bias subtraction, the sign handling and the zero-result encoding. Denormals with the top fraction bit set and with only the lowest bit set probe both ends of the normalising search, and each is run with DAZ low and high. Zeros, infinities, quiet and signalling NaNs sit side by side in one vector, which separates the special-case results from each other and shows which NaN raises the invalid flag. The wrapper is tried with sparse masks in both merging and zeroing mode, with every length select, with broadcast both with and without a memory source, and with a bad reserved field. A signalling NaN is placed in a lane that must not be computed, so a flag that leaks from such a lane shows up.

// File: rtl/gx_pkg.sv
package gx_pkg;

  localparam int unsigned GX_W     = 64;
  localparam int unsigned GX_FRAC  = 52;
  localparam int unsigned GX_BIAS  = 1023;

  typedef logic [GX_W-1:0] gx_word_t;

  typedef struct packed {
    gx_word_t val;
    logic     inv;
    logic     den;
  } gx_res_t;

  // number of zeros above the highest set bit of a non-zero fraction
  function automatic int gx_lead_zeros(input logic [GX_FRAC-1:0] f);
    int  cnt;
    logic hit;
    cnt = GX_FRAC;
    hit = 1'b0;
    for (int i = GX_FRAC - 1; i >= 0; i--) begin
      if (!hit && f[i]) begin
        cnt = GX_FRAC - 1 - i;
        hit = 1'b1;
      end
    end
    return cnt;
  endfunction

  // signed integer (|e| < 2048) to double
  function automatic gx_word_t gx_int_to_dp(input int e);
    int       mag;
    int       p;
    gx_word_t wide;
    logic [10:0] bexp;
    mag = (e < 0) ? -e : e;
    if (mag == 0) return '0;
    p = 0;
    for (int b = 0; b < 11; b++) begin
      if (mag[b]) p = b;
    end
    wide = gx_word_t'(mag) << (GX_FRAC - p);
    bexp = 11'(GX_BIAS + p);
    return {(e < 0), bexp, wide[GX_FRAC-1:0]};
  endfunction

  // floor(log2|x|) as a double, with special cases and flags
  function automatic gx_res_t gx_getexp(input gx_word_t x, input logic daz);
    gx_res_t r;
    logic [10:0] ex;
    logic [GX_FRAC-1:0] fr;
    ex = x[62:52];
    fr = x[51:0];
    r  = '0;
    if (ex == 11'h7FF) begin
      if (fr != '0) begin
        r.val = x | (gx_word_t'(1) << 51);
        r.inv = ~fr[51];
      end else begin
        r.val = 64'h7FF0_0000_0000_0000;
      end
    end else if (ex == '0 && (fr == '0 || daz)) begin
      r.val = 64'hFFF0_0000_0000_0000;
    end else if (ex == '0) begin
      r.val = gx_int_to_dp(-int'(GX_BIAS) - gx_lead_zeros(fr));
      r.den = 1'b1;
    end else begin
      r.val = gx_int_to_dp(int'(ex) - int'(GX_BIAS));
    end
    return r;
  endfunction

endpackage

// File: rtl/gx_lane_ctl.sv
module gx_lane_ctl #(
  parameter int unsigned LANES = 8
) (
  input  logic [1:0]       vl_sel_i,
  input  logic [LANES-1:0] mask_i,
  input  logic             mask_en_i,
  output logic [LANES-1:0] lane_range_o,
  output logic [LANES-1:0] lane_live_o
);

  int unsigned lane_cnt;

  always_comb begin
    lane_cnt = 2 << vl_sel_i;
    if (lane_cnt > LANES) lane_cnt = LANES;
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign lane_range_o[j] = (j < lane_cnt);
    assign lane_live_o[j]  = lane_range_o[j] & (mask_i[j] | ~mask_en_i);
  end

endmodule

// File: rtl/gx_lane_unit.sv
module gx_lane_unit
  import gx_pkg::*;
(
  input  gx_word_t src_i,
  input  gx_word_t prev_i,
  input  logic     in_range_i,
  input  logic     live_i,
  input  logic     zero_mode_i,
  input  logic     daz_i,
  output gx_word_t res_o,
  output logic     inv_o,
  output logic     den_o
);

  gx_res_t calc;

  always_comb begin
    calc = gx_getexp(src_i, daz_i);
    if (!in_range_i)      res_o = '0;
    else if (live_i)      res_o = calc.val;
    else if (zero_mode_i) res_o = '0;
    else                  res_o = prev_i;
    inv_o = live_i & calc.inv;
    den_o = live_i & calc.den;
  end

endmodule

// File: rtl/vexp_lane_wrap.sv
module vexp_lane_wrap
  import gx_pkg::*;
#(
  parameter int unsigned LANES = 8,
  localparam int unsigned VEC_W = LANES * GX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VEC_W-1:0] src_i,
  input  logic [VEC_W-1:0] prev_dst_i,
  input  logic [LANES-1:0] mask_i,
  input  logic             mask_en_i,
  input  logic             zero_mode_i,
  input  logic             bcast_i,
  input  logic             mem_src_i,
  input  logic [1:0]       vl_sel_i,
  input  logic             daz_i,
  input  logic [3:0]       rsvd_i,
  output logic [VEC_W-1:0] dst_o,
  output logic             inv_o,
  output logic             den_o,
  output logic             ud_o
);

  logic [LANES-1:0] lane_range;
  logic [LANES-1:0] lane_live;
  logic [LANES-1:0] lane_inv;
  logic [LANES-1:0] lane_den;
  logic [VEC_W-1:0] vec_res;
  logic             ud_now;
  logic             use_bcast;

  assign ud_now    = (rsvd_i != 4'b1111);
  assign use_bcast = bcast_i & mem_src_i;

  gx_lane_ctl #(.LANES(LANES)) u_ctl (
    .vl_sel_i     (vl_sel_i),
    .mask_i       (mask_i),
    .mask_en_i    (mask_en_i),
    .lane_range_o (lane_range),
    .lane_live_o  (lane_live)
  );

  for (genvar j = 0; j < LANES; j++) begin : g_unit
    gx_word_t lane_src;
    assign lane_src = use_bcast ? src_i[GX_W-1:0] : src_i[j*GX_W +: GX_W];

    gx_lane_unit u_unit (
      .src_i       (lane_src),
      .prev_i      (prev_dst_i[j*GX_W +: GX_W]),
      .in_range_i  (lane_range[j]),
      .live_i      (lane_live[j]),
      .zero_mode_i (zero_mode_i),
      .daz_i       (daz_i),
      .res_o       (vec_res[j*GX_W +: GX_W]),
      .inv_o       (lane_inv[j]),
      .den_o       (lane_den[j])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_o <= '0;
      inv_o <= 1'b0;
      den_o <= 1'b0;
      ud_o  <= 1'b0;
    end else if (ud_now) begin
      dst_o <= prev_dst_i;
      inv_o <= 1'b0;
      den_o <= 1'b0;
      ud_o  <= 1'b1;
    end else begin
      dst_o <= vec_res;
      inv_o <= |lane_inv;
      den_o <= |lane_den;
      ud_o  <= 1'b0;
    end
  end

endmodule

// File: rtl/gx_wrap_checker.sv
module gx_wrap_checker #(
  parameter int unsigned LANES = 8,
  localparam int unsigned VEC_W = LANES * 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic [VEC_W-1:0] prev_dst_i,
  input logic [LANES-1:0] mask_i,
  input logic             mask_en_i,
  input logic             zero_mode_i,
  input logic [1:0]       vl_sel_i,
  input logic [VEC_W-1:0] dst_o,
  input logic             inv_o,
  input logic             den_o,
  input logic             ud_o,
  input logic             ud_now,
  input logic [LANES-1:0] lane_live
);

  AST_UD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    ud_now |=> (ud_o && dst_o == $past(prev_dst_i))); // R9

  AST_UD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ud_now |=> (!inv_o && !den_o)); // R9

  AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!ud_now && vl_sel_i == 2'd0) |=> ((dst_o >> 128) == '0)); // R1

  AST_IDLE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ud_now && lane_live == '0) |=> (!inv_o && !den_o)); // R10

  AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!ud_now && mask_en_i && mask_i == '0 && zero_mode_i) |=> (dst_o == '0)); // R7

  AST_NO_UD: assert property (@(posedge clk) disable iff (!rst_n)
    !ud_now |=> !ud_o); // R9

endmodule

bind vexp_lane_wrap gx_wrap_checker #(.LANES(LANES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .prev_dst_i  (prev_dst_i),
  .mask_i      (mask_i),
  .mask_en_i   (mask_en_i),
  .zero_mode_i (zero_mode_i),
  .vl_sel_i    (vl_sel_i),
  .dst_o       (dst_o),
  .inv_o       (inv_o),
  .den_o       (den_o),
  .ud_o        (ud_o),
  .ud_now      (ud_now),
  .lane_live   (lane_live)
);

// File: tb/vexp_lane_wrap_bench.sv
module vexp_lane_wrap_bench;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [511:0] src_i = '0;
  logic [511:0] prev_dst_i = '0;
  logic [7:0]   mask_i = '0;
  logic         mask_en_i = 1'b0;
  logic         zero_mode_i = 1'b0;
  logic         bcast_i = 1'b0;
  logic         mem_src_i = 1'b0;
  logic [1:0]   vl_sel_i = 2'd2;
  logic         daz_i = 1'b0;
  logic [3:0]   rsvd_i = 4'b1111;
  logic [511:0] dst_o;
  logic         inv_o, den_o, ud_o;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  vexp_lane_wrap u_vexp_lane_wrap (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .prev_dst_i(prev_dst_i),
    .mask_i(mask_i), .mask_en_i(mask_en_i), .zero_mode_i(zero_mode_i),
    .bcast_i(bcast_i), .mem_src_i(mem_src_i), .vl_sel_i(vl_sel_i),
    .daz_i(daz_i), .rsvd_i(rsvd_i), .dst_o(dst_o), .inv_o(inv_o),
    .den_o(den_o), .ud_o(ud_o)
  );

  localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] NINF = 64'hFFF0_0000_0000_0000;

  function automatic logic [63:0] dp(input real v);
    return $realtobits(v);
  endfunction

  // independent lane model: integer exponent found by scanning upward
  task automatic ref_lane(input logic [63:0] x, input logic daz,
                          output logic [63:0] r, output logic ie, output logic de);
    logic [10:0] e11;
    logic [51:0] f;
    int k, top;
    e11 = x[62:52]; f = x[51:0]; ie = 1'b0; de = 1'b0; r = '0;
    if (e11 == 11'h7FF) begin
      if (f != 0) begin r = x; r[51] = 1'b1; ie = !f[51]; end
      else r = PINF;
    end else if (e11 == 0 && (f == 0 || daz)) begin
      r = NINF;
    end else begin
      if (e11 == 0) begin
        top = 0;
        for (int b = 0; b < 52; b++) if (f[b]) top = b;
        k = top - 1074; de = 1'b1;
      end else k = int'(e11) - 1023;
      r = $realtobits($itor(k));
    end
  endtask

  task automatic check1(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // compare all outputs against the model for the inputs now held
  task automatic check_vec(input string req);
    logic [511:0] ed;
    logic eie, ede, eud;
    int cnt;
    logic [63:0] r, s;
    logic li, ld, live;
    cnt = (vl_sel_i == 0) ? 2 : (vl_sel_i == 1) ? 4 : 8;
    eie = 0; ede = 0; eud = (rsvd_i != 4'b1111);
    for (int j = 0; j < 8; j++) begin
      s = (bcast_i && mem_src_i) ? src_i[63:0] : src_i[j*64 +: 64];
      ref_lane(s, daz_i, r, li, ld);
      live = (j < cnt) && (!mask_en_i || mask_i[j]);
      if (j >= cnt)        ed[j*64 +: 64] = '0;
      else if (live)       ed[j*64 +: 64] = r;
      else if (zero_mode_i) ed[j*64 +: 64] = '0;
      else                 ed[j*64 +: 64] = prev_dst_i[j*64 +: 64];
      if (live) begin eie |= li; ede |= ld; end
    end
    if (eud) begin ed = prev_dst_i; eie = 0; ede = 0; end
    for (int j = 0; j < 8; j++)
      check1(req, $sformatf("lane%0d", j), dst_o[j*64 +: 64], ed[j*64 +: 64]);
    check1(req, "inv", 64'(inv_o), 64'(eie));
    check1(req, "den", 64'(den_o), 64'(ede));
    check1(req, "ud", 64'(ud_o), 64'(eud));
  endtask

  task automatic step_and_check(input string req);
    @(posedge clk); #1;
    check_vec(req);
    @(negedge clk);
  endtask

  task automatic defaults();
    mask_i = '0; mask_en_i = 0; zero_mode_i = 0; bcast_i = 0; mem_src_i = 0;
    vl_sel_i = 2'd2; daz_i = 0; rsvd_i = 4'b1111;
    for (int j = 0; j < 8; j++) prev_dst_i[j*64 +: 64] = 64'hA5A5_0000_0000_0000 | 64'(j);
  endtask

  task automatic t_reset();
    #1;
    check1("R11", "reset dst", dst_o[63:0] | dst_o[511:448], 64'h0);
    check1("R11", "reset flags", {61'b0, inv_o, den_o, ud_o}, 64'h0);
  endtask

  task automatic t_normal();
    defaults();
    src_i = {dp(1.0), dp(8.0), dp(-0.75), dp(3.0e10), 64'h7FEF_FFFF_FFFF_FFFF,
             64'h0010_0000_0000_0000, dp(0.5), dp(-1.5)};
    step_and_check("R2");
    check1("R2", "exp1023 gives +0", dst_o[511:448], 64'h0);
    check1("R2", "max normal", dst_o[255:192], dp(1023.0));
  endtask

  task automatic t_special();
    defaults();
    src_i = {64'h0, 64'h8000_0000_0000_0000, PINF, NINF,
             64'h7FF8_0000_0000_0001, 64'hFFF0_0000_0000_0005,
             64'h0000_0000_0000_0001, 64'h800F_FFFF_FFFF_FFFF};
    step_and_check("R4 R5 R3");
    check1("R5", "snan quietened", dst_o[191:128], 64'hFFF8_0000_0000_0005);
    check1("R3", "min denormal", dst_o[127:64], dp(-1074.0));
    check1("R3", "top denormal", dst_o[63:0], dp(-1023.0));
    daz_i = 1;
    step_and_check("R3");
    check1("R3", "daz denormal", dst_o[63:0], NINF);
  endtask

  task automatic t_mask();
    defaults();
    src_i = {dp(2.0), dp(4.0), dp(16.0), 64'h7FF0_0000_0000_0001,
             dp(0.25), dp(1024.0), 64'h0000_0000_0000_0010, dp(3.0)};
    mask_en_i = 1; mask_i = 8'b1010_0101;
    step_and_check("R6 R7");
    check1("R7", "merge kept", dst_o[127:64], prev_dst_i[127:64]);
    check1("R10", "snan masked no inv", 64'(inv_o), 64'h0);
    zero_mode_i = 1;
    step_and_check("R7 R10");
    check1("R7", "zeroed lane", dst_o[127:64], 64'h0);
    mask_i = 8'b0001_0000;
    step_and_check("R10");
    check1("R10", "snan live inv", 64'(inv_o), 64'h1);
  endtask

  task automatic t_length();
    defaults();
    src_i = {dp(2.0), dp(4.0), 64'h7FF0_0000_0000_0001, 64'h7FF0_0000_0000_0001,
             dp(0.25), dp(1024.0), dp(6.0), dp(3.0)};
    for (int v = 0; v < 4; v++) begin
      vl_sel_i = 2'(v);
      step_and_check("R1");
    end
    vl_sel_i = 2'd0; mask_en_i = 1; mask_i = 8'b1111_1101;
    step_and_check("R10");
    check1("R10", "mask above length", dst_o[511:128], 64'h0);
    check1("R1", "lane1 merged", dst_o[127:64], prev_dst_i[127:64]);
  endtask

  task automatic t_bcast();
    defaults();
    src_i = {dp(2.0), dp(4.0), dp(16.0), dp(32.0), dp(0.25), dp(1024.0), dp(6.0), dp(-9.0)};
    bcast_i = 1; mem_src_i = 1;
    step_and_check("R8");
    check1("R8", "bcast lane7", dst_o[511:448], dp(3.0));
    mem_src_i = 0;
    step_and_check("R8");
    check1("R8", "no bcast lane7", dst_o[511:448], dp(1.0));
  endtask

  task automatic t_ud();
    defaults();
    src_i = {8{64'h7FF0_0000_0000_0001}};
    rsvd_i = 4'b0111;
    step_and_check("R9");
    check1("R9", "ud prev", dst_o[511:448], prev_dst_i[511:448]);
    rsvd_i = 4'b1111;
    step_and_check("R9");
  endtask

  task automatic t_latency();
    logic [63:0] held;
    defaults();
    src_i = {8{dp(8.0)}};
    step_and_check("R11");
    held = dst_o[63:0];
    src_i = {8{dp(64.0)}};
    #1;
    check1("R11", "holds before edge", dst_o[63:0], held);
    @(posedge clk); #1;
    check1("R11", "updates after edge", dst_o[63:0], dp(6.0));
    @(negedge clk);
  endtask

  initial begin
    defaults();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_normal();
    t_special();
    t_mask();
    t_length();
    t_bcast();
    t_ud();
    t_latency();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule